// File: doc/BRIEF.md
# Caption Line Data Inserter

This block overlays caption data on one video line in each field. When the raster reaches the chosen line and the horizontal sample count reaches a fixed start point, the block takes over the luma path. It sends a sinusoidal clock run-in, one start bit and two 8-bit characters. It drives a luma level for the overriding sample and raises a flag while it holds the line. Downstream logic selects this level in place of the picture luma while the flag is high.

Four character registers are written by the host: two for field 1 and two for field 2. Each register stores seven data bits with an odd-parity bit in bit 7. Writes land in a shadow copy. The shadow copy moves to the transmitted copy on the falling edge of frame sync, so characters written in one frame go out in the next frame. The bit period is one thirty-second of a line. It is produced from the sample clock by a power-of-two phase accumulator, so no divider is needed and the rounding error stays well below one clock across a line.

The controller is a four-state machine:
- IDLE waits for the trigger.
- RUNIN sends seven sine cycles, one per bit period.
- START sends the high start bit.
- DATA shifts out 16 bits and then returns to IDLE.

The trigger is the move IDLE→RUNIN. It fires on a matching line, at the start sample, with that field enabled. The other moves are RUNIN→START after the seventh bit tick, START→DATA after one tick, and DATA→IDLE after the sixteenth tick.

Top module: `cc_line_encoder`

## Requirements
- R1: Insertion happens only on line 21 (field 1) or line 284 (field 2) when `std625` is 0. When `std625` is 1 it happens only on line 22 (field 1) or line 335 (field 2). The field is given by `field2` (0 = field 1, 1 = field 2). No other line is touched.
- R2: After reset all four character registers hold 0x80. With no writes, an enabled line therefore carries seven low bits and then a high parity bit for each character.
- R3: Write address 4 holds the enables: data bit 0 enables field 1 and data bit 1 enables field 2. Both are 0 after reset. A disabled field leaves `cc_active` low and `cc_level` at the blank level.
- R4: The insertion starts when `h_cnt` equals START_CLK (284 clocks, about 10.5 µs) on a qualifying line. `cc_active` rises two clocks later.
- R5: The run-in lasts 7 bit periods. Each period is one cosine cycle that starts at the blank level and peaks at the high level at mid-period.
- R6: A start bit at the high level follows the run-in and lasts one bit period.
- R7: Each field sends two characters. For field 1 these are the registers at addresses 0 and 1; for field 2, addresses 2 and 3. The lower-address character goes first. Each character is sent as data bit 0 first through data bit 6, then parity bit 7 last.
- R8: Writes to addresses 0 to 3 update only the shadow copy. The transmitted copy takes the shadow value on a falling edge of `fsync` and holds it otherwise.
- R9: A data bit of 1 is sent at LVL_HI (126, the 50 IRE level) and a 0 at LVL_LO (16, the 0 IRE level). With `cc_active` low, `cc_level` is LVL_LO.
- R10: The bit period is 1/32 of the line length: 1716 clocks per line when `std625` is 0 and 1728 when it is 1. The whole insertion lasts 24 bit periods, about 1287 or 1296 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (27 MHz in the target system) |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_num | input | 10 | Current line number of the raster |
| field2 | input | 1 | 0 = field 1, 1 = field 2 |
| h_cnt | input | 11 | Sample count since the line reference |
| fsync | input | 1 | Frame sync; its falling edge moves shadow characters to the transmitted copy |
| std625 | input | 1 | 0 = 525-line raster, 1 = 625-line raster |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | 0 to 3 = character registers, 4 = field enables |
| wr_data | input | 8 | Host write data |
| cc_level | output | 8 | Luma override level |
| cc_active | output | 1 | High while the block overrides the line |

## Verification
The assertions assume that `h_cnt` advances by one per clock from the line reference, so the sample two clocks before `cc_active` rises is START_CLK. They also assume that `line_num`, `field2` and `std625` stay stable for a whole line. The bench drives the sample counter one step per clock through a full line of the selected standard. It changes line, field and standard only between lines, and it sends writes and frame-sync pulses only while no insertion is in progress.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUNIN,
        ST_START,
        ST_DATA
    } cc_state_t;

    // cosine of idx * 22.5 degrees, scaled by 1000
    function automatic int cos_milli(input logic [3:0] idx);
        int r;
        unique case (idx)
            4'd0:  r = 1000;
            4'd1:  r = 924;
            4'd2:  r = 707;
            4'd3:  r = 383;
            4'd4:  r = 0;
            4'd5:  r = -383;
            4'd6:  r = -707;
            4'd7:  r = -924;
            4'd8:  r = -1000;
            4'd9:  r = -924;
            4'd10: r = -707;
            4'd11: r = -383;
            4'd12: r = 0;
            4'd13: r = 383;
            4'd14: r = 707;
            default: r = 924;
        endcase
        return r;
    endfunction

    // run-in sample: starts at lo, peaks at hi half-way through the period
    function automatic logic [7:0] runin_level(input logic [3:0] idx,
                                               input int lo, input int hi);
        int mid;
        int amp;
        mid = (lo + hi) / 2;
        amp = (hi - lo) / 2;
        return 8'(mid - (amp * cos_milli(idx)) / 1000);
    endfunction

endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
    parameter int ACC_W         = 24,
    parameter int LINE_525      = 1716,
    parameter int LINE_625      = 1728,
    parameter int BITS_PER_LINE = 32,
    parameter int PH_W          = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            std625,
    output logic            tick,
    output logic [PH_W-1:0] phase
);
    localparam longint FULL    = longint'(1) << ACC_W;
    localparam logic [ACC_W:0] INC_A =
        (ACC_W+1)'((FULL * BITS_PER_LINE + LINE_525 / 2) / LINE_525);
    localparam logic [ACC_W:0] INC_B =
        (ACC_W+1)'((FULL * BITS_PER_LINE + LINE_625 / 2) / LINE_625);
    localparam int MIN_GAP = LINE_525 / BITS_PER_LINE;

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum   = {1'b0, acc} + (std625 ? INC_B : INC_A);
    assign tick  = run & sum[ACC_W];
    assign phase = acc[ACC_W-1 -: PH_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (run) acc <= sum[ACC_W-1:0];
        else          acc <= '0;
    end

    // clocks since the last tick or since the timer was idle
    logic [7:0] gap_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  gap_cnt <= '0;
        else if (!run || tick)       gap_cnt <= '0;
        else if (gap_cnt != 8'hFF)   gap_cnt <= gap_cnt + 8'd1;
    end

    // R10: bit ticks are never closer than one bit period of the shorter line
    p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (int'(gap_cnt) >= MIN_GAP - 1));

endmodule

// File: rtl/cc_char_regs.sv
module cc_char_regs #(
    parameter int          CHAR_W    = 8,
    parameter int          NUM_CHARS = 4,
    parameter logic [7:0]  RST_CHAR  = 8'h80
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [$clog2(NUM_CHARS+1)-1:0]       wr_addr,
    input  logic [CHAR_W-1:0]                    wr_data,
    input  logic                                 fsync,
    output logic [NUM_CHARS-1:0][CHAR_W-1:0]     act_chars,
    output logic [1:0]                           en_mask
);
    localparam int ADDR_W = $clog2(NUM_CHARS + 1);

    logic [NUM_CHARS-1:0][CHAR_W-1:0] shadow;
    logic fsync_q;
    logic fs_fall;
    logic unused_ctrl;

    assign fs_fall     = fsync_q & ~fsync;
    assign unused_ctrl = ^wr_data[CHAR_W-1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsync_q <= 1'b0;
        else        fsync_q <= fsync;
    end

    for (genvar g = 0; g < NUM_CHARS; g++) begin : g_char
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[g]    <= CHAR_W'(RST_CHAR);
                act_chars[g] <= CHAR_W'(RST_CHAR);
            end else begin
                if (wr_en && wr_addr == ADDR_W'(g)) shadow[g] <= wr_data;
                if (fs_fall)                        act_chars[g] <= shadow[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    en_mask <= 2'b00;
        else if (wr_en && wr_addr == ADDR_W'(NUM_CHARS)) en_mask <= wr_data[1:0];
    end

    // R8: transmitted characters change only right after a frame-sync fall
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_fall |=> $stable(act_chars));

    // R8: a write without a frame-sync fall leaves the transmitted copy alone
    p_write_shadow_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fs_fall) |=> $stable(act_chars));

endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
    import cc_pkg::*;
#(
    parameter int LINE_W      = 10,
    parameter int H_W         = 11,
    parameter int START_CLK   = 284,
    parameter int F1_LINE_525 = 21,
    parameter int F2_LINE_525 = 284,
    parameter int F1_LINE_625 = 22,
    parameter int F2_LINE_625 = 335,
    parameter int LVL_LO      = 16,
    parameter int LVL_HI      = 126,
    parameter int RUNIN_BITS  = 7,
    parameter int DATA_BITS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field2,
    input  logic [H_W-1:0]    h_cnt,
    input  logic              fsync,
    input  logic              std625,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        cc_level,
    output logic              cc_active
);
    localparam int CNT_W = $clog2(DATA_BITS + 1);

    cc_state_t                state, state_nx;
    logic [CNT_W-1:0]         bit_cnt;
    logic [DATA_BITS-1:0]     shreg;
    logic [3:0][7:0]          act_chars;
    logic [1:0]               en_mask;
    logic                     tick;
    logic [3:0]               phase;
    logic [LINE_W-1:0]        tgt_line;
    logic                     trigger;

    cc_char_regs #(.CHAR_W(8), .NUM_CHARS(4), .RST_CHAR(8'h80)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fsync    (fsync),
        .act_chars(act_chars),
        .en_mask  (en_mask)
    );

    cc_bit_timer #(.ACC_W(24), .LINE_525(1716), .LINE_625(1728),
                   .BITS_PER_LINE(32), .PH_W(4)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .std625(std625),
        .tick  (tick),
        .phase (phase)
    );

    always_comb begin
        if (std625) tgt_line = field2 ? LINE_W'(F2_LINE_625) : LINE_W'(F1_LINE_625);
        else        tgt_line = field2 ? LINE_W'(F2_LINE_525) : LINE_W'(F1_LINE_525);
    end

    assign trigger = (line_num == tgt_line) && (h_cnt == H_W'(START_CLK))
                   && (field2 ? en_mask[1] : en_mask[0]);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (trigger) state_nx = ST_RUNIN;
            ST_RUNIN: if (tick && bit_cnt == CNT_W'(RUNIN_BITS - 1)) state_nx = ST_START;
            ST_START: if (tick) state_nx = ST_DATA;
            ST_DATA:  if (tick && bit_cnt == CNT_W'(DATA_BITS - 1)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register, bit counter and character shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) bit_cnt <= '0;
            else if (tick)         bit_cnt <= bit_cnt + 1'b1;
            if (state == ST_IDLE && trigger)
                shreg <= field2 ? {act_chars[3], act_chars[2]}
                                : {act_chars[1], act_chars[0]};
            else if (state == ST_DATA && tick)
                shreg <= {1'b0, shreg[DATA_BITS-1:1]};
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_active <= 1'b0;
            cc_level  <= 8'(LVL_LO);
        end else begin
            cc_active <= (state != ST_IDLE);
            unique case (state)
                ST_IDLE:  cc_level <= 8'(LVL_LO);
                ST_RUNIN: cc_level <= runin_level(phase, LVL_LO, LVL_HI);
                ST_START: cc_level <= 8'(LVL_HI);
                ST_DATA:  cc_level <= shreg[0] ? 8'(LVL_HI) : 8'(LVL_LO);
                default:  cc_level <= 8'(LVL_LO);
            endcase
        end
    end

    // R4: the insertion begins two clocks after the start sample
    p_start_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> ($past(h_cnt, 2) == H_W'(START_CLK)));

    // R9: outside an insertion the output rests at the blank level
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> (cc_level == 8'(LVL_LO)));

    // R9: data bits use only the two logic levels
    p_data_binary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |=> (cc_level == 8'(LVL_HI) || cc_level == 8'(LVL_LO)));

    // R5: the run-in never counts past its seven periods
    p_runin_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNIN) |-> (int'(bit_cnt) < RUNIN_BITS));

    // R6: the start bit lasts exactly one tick
    p_start_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick) |=> (state == ST_DATA));

endmodule

// File: tb/cc_line_encoder_test.sv
`timescale 1ns/1ps
module cc_line_encoder_test;
    localparam int START = 284;
    localparam int LO    = 16;
    localparam int HI    = 126;
    localparam int MID   = 71;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] line_num = '0;
    logic       field2 = 1'b0;
    logic [10:0] h_cnt = '0;
    logic       fsync = 1'b0;
    logic       std625 = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cc_level;
    logic       cc_active;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] cap_lvl [0:2047];
    logic       cap_act [0:2047];

    always #10 clk = ~clk;

    cc_line_encoder uut (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .field2(field2),
        .h_cnt(h_cnt), .fsync(fsync), .std625(std625), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cc_level(cc_level),
        .cc_active(cc_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fsync_pulse();
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); @(negedge clk); fsync = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic run_line(input int ln, input bit f2, input bit s625);
        int len;
        len = s625 ? 1728 : 1716;
        @(negedge clk);
        line_num = 10'(ln); field2 = f2; std625 = s625;
        for (int h = 0; h < len; h++) begin
            @(negedge clk);
            cap_lvl[h] = cc_level;
            cap_act[h] = cc_active;
            h_cnt = 11'(h);
        end
        @(negedge clk);
        line_num = '0; h_cnt = '0;
    endtask

    function automatic int at(input real pos);
        return START + 2 + $rtoi(pos + 0.5);
    endfunction

    // whole line stayed blank
    task automatic check_quiet(input string req);
        int bad;
        bad = 0;
        for (int h = 0; h < 1716; h++)
            if (cap_act[h] || cap_lvl[h] != 8'(LO)) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_frame(input logic [7:0] c1, input logic [7:0] c2,
                               input bit s625, input string req_data);
        real p;
        logic [15:0] bits;
        int  ix;
        p = (s625 ? 1728.0 : 1716.0) / 32.0;
        bits = {c2, c1};
        check(cap_act[at(0.0)] == 1'b1, "R4 active at start", int'(cap_act[at(0.0)]), 1);
        check(cap_act[at(0.0) - 2] == 1'b0, "R4 quiet before start", int'(cap_act[at(0.0) - 2]), 0);
        for (int k = 0; k < 7; k++) begin
            ix = at(k * p) + 4;
            check(int'(cap_lvl[ix]) < MID - 30, "R5 run-in low", int'(cap_lvl[ix]), LO);
            ix = at((k + 0.5) * p);
            check(int'(cap_lvl[ix]) > MID + 30, "R5 run-in high", int'(cap_lvl[ix]), HI);
        end
        ix = at(7.5 * p);
        check(cap_lvl[ix] == 8'(HI), "R6 start bit", int'(cap_lvl[ix]), HI);
        for (int j = 0; j < 16; j++) begin
            ix = at((8 + j + 0.5) * p);
            check(cap_lvl[ix] == (bits[j] ? 8'(HI) : 8'(LO)), req_data,
                  int'(cap_lvl[ix]), bits[j] ? HI : LO);
        end
        ix = at(24.0 * p) - 4;
        check(cap_act[ix] == 1'b1, "R10 still active near end", int'(cap_act[ix]), 1);
        ix = at(24.0 * p) + 4;
        check(cap_act[ix] == 1'b0, "R10 ended after 24 bits", int'(cap_act[ix]), 0);
        check(cap_lvl[ix] == 8'(LO), "R9 blank after end", int'(cap_lvl[ix]), LO);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cc_active == 1'b0, "R9 reset flag", int'(cc_active), 0);
        check(cc_level == 8'(LO), "R9 reset level", int'(cc_level), LO);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_disabled_default();
        run_line(21, 1'b0, 1'b0);
        check_quiet("R3 field1 off after reset");
    endtask

    task automatic test_null_chars();
        write_reg(3'd4, 8'h01);
        run_line(21, 1'b0, 1'b0);
        check_frame(8'h80, 8'h80, 1'b0, "R2 null characters");
        run_line(284, 1'b1, 1'b0);
        check_quiet("R3 field2 still off");
    endtask

    task automatic test_double_buffer();
        write_reg(3'd0, 8'hC1);
        write_reg(3'd1, 8'h52);
        run_line(21, 1'b0, 1'b0);
        check_frame(8'h80, 8'h80, 1'b0, "R8 shadow not yet sent");
        fsync_pulse();
        run_line(21, 1'b0, 1'b0);
        check_frame(8'hC1, 8'h52, 1'b0, "R7 bit order field1");
    endtask

    task automatic test_field2_and_625();
        write_reg(3'd4, 8'h03);
        write_reg(3'd2, 8'h2A);
        write_reg(3'd3, 8'hB5);
        fsync_pulse();
        run_line(284, 1'b1, 1'b0);
        check_frame(8'h2A, 8'hB5, 1'b0, "R7 field2 525 characters");
        run_line(21, 1'b0, 1'b1);
        check_quiet("R1 line 21 ignored on 625");
        run_line(20, 1'b0, 1'b0);
        check_quiet("R1 line 20 ignored on 525");
        run_line(335, 1'b1, 1'b1);
        check_frame(8'h2A, 8'hB5, 1'b1, "R1 field2 line 335");
        run_line(22, 1'b0, 1'b1);
        check_frame(8'hC1, 8'h52, 1'b1, "R10 field1 line 22 625 timing");
    endtask

    task automatic test_disable_again();
        write_reg(3'd4, 8'h02);
        run_line(21, 1'b0, 1'b0);
        check_quiet("R3 field1 disabled by write");
    endtask

    initial begin
        test_reset();
        test_disabled_default();
        test_null_chars();
        test_double_buffer();
        test_field2_and_625();
        test_disable_again();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule